// File: doc/BRIEF.md
# Zero Common-Mode Five-Level State Generator

This block produces the per-phase switching level of a three-phase five-level inverter. The sum of the three levels is always zero, so the common-mode voltage is zero. Its inputs are three signed reference samples, one per phase, and a tick that advances the modulator by one step. A symmetric up/down counter forms a triangular carrier. Two carriers are derived from it. The upper carrier runs from zero up to the programmed peak. The lower carrier is the same shape shifted down by the peak, so it runs from minus the peak up to zero.

Each phase compares its latched reference against both carriers. The result is a three-level state of 0, 1 or 2. The three-level triple is then turned into a five-level triple by taking the difference of neighbouring phases. This lands on one of the 19 zero-sum vectors, and redundant three-level vectors collapse onto a single output. The levels +2, +1, 0, −1 and −2 stand for half, a quarter, zero, minus a quarter and minus half of the dc-link voltage, measured from its midpoint. The capacitor-balancing choice among redundant switch patterns and the gate drive happen downstream.

Top module: `zcm_level_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, all three levels become 0 and `valid_o` becomes 0. The counter restarts at 0 rising, and the latched references are cleared to 0.
- R2: Each tick moves the counter by one step. While rising, it counts up until it is at or above `period_i`. It then turns and continues from `period_i`−1. While falling, it counts down to 0 and then turns up to 1. A cycle without a tick leaves every state unchanged.
- R3: The references are captured only on a tick where the counter is rising and at or above `period_i`. Reference changes at any other time have no effect until the next such capture.
- R4: A phase's three-level state is 2 if the latched reference is greater than the counter. It is 0 if the reference is less than the counter minus `period_i`. Otherwise it is 1. Comparisons are signed.
- R5: With three-level states la, lb and lc, the outputs are a = la−lb, b = lb−lc and c = lc−la. Examples: 200 gives (2,0,−2). Both 211 and 100 give (1,0,−1). 210 gives (1,1,−2). 020 gives (−2,2,0). 201 gives (2,−1,−1). 000, 111 and 222 all give (0,0,0).
- R6: The three levels, each a 3-bit two's-complement value, always lie in −2..+2 and always sum to zero.
- R7: `valid_o` is high exactly in the cycle after a tick edge. The levels change only at a tick edge.
- R8: The levels registered at a tick edge are computed from the counter and latched references as they stood before that edge.
- R9: With `period_i` = 0 the counter stays at 0. Each state is then 2 for a positive reference, 0 for a negative one and 1 for zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Modulator step strobe |
| period_i | input | CNT_W | Carrier peak value |
| ref_a_i | input | REF_W | Phase A reference, signed |
| ref_b_i | input | REF_W | Phase B reference, signed |
| ref_c_i | input | REF_W | Phase C reference, signed |
| lvl_a_o | output | 3 | Phase A level, signed −2..+2 |
| lvl_b_o | output | 3 | Phase B level, signed −2..+2 |
| lvl_c_o | output | 3 | Phase C level, signed −2..+2 |
| valid_o | output | 1 | High in the cycle after a tick |

## Verification
A result for a tick is due one cycle after the edge that sampled the tick. The bench drives inputs on the falling edge and reads the levels and `valid_o` on the next falling edge. It predicts the result from the carrier position and captured references held before that edge. A reference presented during a capture tick first shows in the output of the following tick, so the model captures it only after computing the expected levels. On cycles without a tick, the bench expects the previous levels unchanged and `valid_o` low.

// File: rtl/zcm_level_gen.sv
module zcm_level_gen #(
  parameter int REF_W = 16,
  parameter int CNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick_i,
  input  logic        [CNT_W-1:0] period_i,
  input  logic signed [REF_W-1:0] ref_a_i,
  input  logic signed [REF_W-1:0] ref_b_i,
  input  logic signed [REF_W-1:0] ref_c_i,
  output logic signed [2:0]       lvl_a_o,
  output logic signed [2:0]       lvl_b_o,
  output logic signed [2:0]       lvl_c_o,
  output logic                    valid_o
);
  localparam int XW = ((REF_W > CNT_W) ? REF_W : CNT_W) + 2;
  localparam int NPH = 3;

  logic [CNT_W-1:0] cnt;
  logic             rising;
  logic             at_peak;

  logic signed [REF_W-1:0] ref_in [NPH];
  logic signed [REF_W-1:0] ref_q  [NPH];
  logic        [1:0]       st     [NPH];
  logic signed [2:0]       lvl_d  [NPH];
  logic signed [2:0]       lvl_q  [NPH];

  logic signed [XW-1:0] up_x, per_x, lo_x;

  assign at_peak = rising && (cnt >= period_i);
  assign up_x    = {{(XW-CNT_W){1'b0}}, cnt};
  assign per_x   = {{(XW-CNT_W){1'b0}}, period_i};
  assign lo_x    = up_x - per_x;

  assign ref_in[0] = ref_a_i;
  assign ref_in[1] = ref_b_i;
  assign ref_in[2] = ref_c_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      rising <= 1'b1;
    end else if (tick_i) begin
      if (rising) begin
        if (at_peak) begin
          rising <= 1'b0;
          cnt    <= (period_i == '0) ? '0 : period_i - 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        if (cnt == '0) begin
          rising <= 1'b1;
          cnt    <= (period_i == '0) ? '0 : {{(CNT_W-1){1'b0}}, 1'b1};
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    logic signed [XW-1:0] r_x;
    assign r_x   = {{(XW-REF_W){ref_q[p][REF_W-1]}}, ref_q[p]};
    assign st[p] = (r_x > up_x) ? 2'd2 : (r_x < lo_x) ? 2'd0 : 2'd1;
    assign lvl_d[p] = $signed({1'b0, st[p]}) - $signed({1'b0, st[(p+1)%NPH]});

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ref_q[p] <= '0;
        lvl_q[p] <= '0;
      end else if (tick_i) begin
        lvl_q[p] <= lvl_d[p];
        if (at_peak) ref_q[p] <= ref_in[p];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) valid_o <= 1'b0;
    else        valid_o <= tick_i;
  end

  assign lvl_a_o = lvl_q[0];
  assign lvl_b_o = lvl_q[1];
  assign lvl_c_o = lvl_q[2];
endmodule

// File: rtl/zcm_level_gen_chk.sv
module zcm_level_gen_chk (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_i,
  input logic signed [2:0] lvl_a_o,
  input logic signed [2:0] lvl_b_o,
  input logic signed [2:0] lvl_c_o,
  input logic              valid_o
);
  logic signed [4:0] sum;
  assign sum = {{2{lvl_a_o[2]}}, lvl_a_o} + {{2{lvl_b_o[2]}}, lvl_b_o} + {{2{lvl_c_o[2]}}, lvl_c_o};

  assert_sum_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sum == 5'sd0);

  assert_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_a_o >= -3'sd2) && (lvl_b_o >= -3'sd2) && (lvl_c_o >= -3'sd2) &&
    (lvl_a_o <= 3'sd2) && (lvl_b_o <= 3'sd2) && (lvl_c_o <= 3'sd2));

  assert_valid_after_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(tick_i));

  assert_hold_no_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(tick_i)) |-> ($stable(lvl_a_o) && $stable(lvl_b_o) && $stable(lvl_c_o)));
endmodule

bind zcm_level_gen zcm_level_gen_chk u_chk (.*);

// File: tb/zcm_level_gen_tb.sv
module zcm_level_gen_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic               rst_n = 1'b0;
  logic               tick = 1'b0;
  logic        [15:0] period = 16'd4;
  logic signed [15:0] ra = '0, rb = '0, rc = '0;
  logic signed [2:0]  la, lb, lc;
  logic               valid;

  int vec = 0, bad = 0;
  bit done = 0;
  int m_cnt = 0, m_up = 1;
  int m_rq[3] = '{0, 0, 0};
  int prev[3] = '{0, 0, 0};

  zcm_level_gen u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .period_i(period),
    .ref_a_i(ra), .ref_b_i(rb), .ref_c_i(rc),
    .lvl_a_o(la), .lvl_b_o(lb), .lvl_c_o(lc), .valid_o(valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int three_lvl(input int r, input int c, input int p);
    if (r > c) return 2;
    if (r < c - p) return 0;
    return 1;
  endfunction

  task automatic cyc(input bit tk, input int k);
    int st[3];
    int ex[3];
    int act[3];
    int per;
    string tag;
    tick = tk;
    ra = 16'(((k * 7) % 13) - 6);
    rb = 16'(((k * 5 + 3) % 13) - 6);
    rc = 16'(((k * 11 + 1) % 13) - 6);
    per = int'(period);
    ex = prev;
    if (tk) begin
      for (int p = 0; p < 3; p++) st[p] = three_lvl(m_rq[p], m_cnt, per);
      for (int p = 0; p < 3; p++) ex[p] = st[p] - st[(p + 1) % 3];
      if (m_up == 1) begin
        if (m_cnt >= per) begin
          m_rq[0] = int'(ra); m_rq[1] = int'(rb); m_rq[2] = int'(rc);
          m_up = 0;
          m_cnt = (per == 0) ? 0 : per - 1;
        end else m_cnt++;
      end else begin
        if (m_cnt == 0) begin
          m_up = 1;
          m_cnt = (per == 0) ? 0 : 1;
        end else m_cnt--;
      end
    end
    @(negedge clk);
    act[0] = int'(la); act[1] = int'(lb); act[2] = int'(lc);
    chk(valid == tk, "R7 valid", int'(valid), int'(tk));
    tag = (per == 0) ? "R9 R4 R5 level" : (tk ? "R2 R3 R4 R5 R8 level" : "R7 hold");
    for (int p = 0; p < 3; p++) chk(act[p] == ex[p], tag, act[p], ex[p]);
    chk(act[0] + act[1] + act[2] == 0, "R6 zero sum", act[0] + act[1] + act[2], 0);
    prev = act;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick = 1'b1;
    repeat (3) @(negedge clk);
    chk(valid == 1'b0, "R1 valid", int'(valid), 0);
    chk(la == 0 && lb == 0 && lc == 0, "R1 levels", int'(la), 0);
    rst_n = 1'b1;
    for (int k = 0; k < 2000; k++) cyc((k % 5) != 2, k);
    period = 16'd1;
    for (int k = 0; k < 300; k++) cyc((k % 3) != 0, k + 7);
    period = 16'd0;
    for (int k = 0; k < 300; k++) cyc((k % 4) != 1, k + 3);
    period = 16'd7;
    for (int k = 0; k < 1500; k++) cyc((k % 7) != 4, k + 11);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule